// File: doc/BRIEF.md
# Time-Slotted DRAM Command Scheduler with Refresh

This block issues DRAM commands on a fixed time-division schedule. Time is cut into slots of `SL` clock cycles. Ownership of the slots rotates over `SN` requestors in a fixed order. A requestor may begin at most one access, and only at the first cycle of its own slot. That access is a precharge, then an activate, then a read or write. Each of the three lands at a fixed cycle offset inside the slot. Because of this, the worst-case latency of any requestor does not depend on what the other requestors do.

Requests arrive one per cycle at most, each with its owner id, bank group, bank, row and direction. They are kept in arrival order in an internal pending store. A refresh interval counter runs alongside the slot schedule. When a full rotation of slots would no longer finish before the refresh deadline, no new access is started. At the deadline the block issues precharge-all, then refresh, and then resumes.

All DRAM timing values are elaboration-time parameters. A parameter set that cannot meet the fixed offsets stops elaboration. This includes a slot too short for the activate-to-column delay, for the row cycle time, or for the row-active time, and a four-activate window that is too long.

Top module: `tdm_cmd_arbiter`

## Requirements
- R1: A synchronous active-high reset sets the scheduler to idle, zeroes the cycle, slot and refresh counters, and empties the pending store. The command output then reads NOP with valid low and all request fields zero.
- R2: The in-slot cycle counter runs 0 to SL-1 and wraps. The slot owner moves to the next id only on that wrap, going from SN-1 back to 0. Both counters run in every state, so the first slot of owner 1 starts SL cycles after reset release.
- R3: When idle, at cycle 0 of a slot, with refresh room available: if the slot owner has a pending request, the block emits PRE carrying the oldest pending request of that owner. That request leaves the store and the block becomes busy with it.
- R4: While busy, ACT appears T_RP cycles after PRE and the column command T_RP+T_RCD cycles after PRE, both carrying the current request. The column command is RD if the write bit is 0 and WR if it is 1. Every other busy cycle is a NOP that still presents the current request. The last cycle of the slot is a NOP with zero fields and returns the block to idle.
- R5: A new access starts only if the refresh counter plus SN*SL is below T_REFI-T_RP. Otherwise pending requests wait, even at the owner's slot start.
- R6: When the refresh counter reaches T_REFI-T_RP while idle, the block emits PREA, clears the refresh counter and enters refresh.
- R7: In refresh, REF is emitted when the refresh counter equals T_RP-1, that is T_RP cycles after PREA. At T_RP-1+T_RFC the block returns to idle and the refresh counter restarts at 0.
- R8: The pending store keeps arrival order. A request that arrives in the same cycle as a removal is appended after the removal. A request that arrives while the store is full after that removal is discarded.
- R9: Commands are registered and appear one cycle after the decision. The codes are NOP 0, PRE 1, ACT 2, RD 3, WR 4, PREA 5, REF 6. Valid is high exactly when the code is not NOP. Outside the busy state the request fields are zero on NOP, PREA and REF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | A new request is present this cycle |
| req_id_i | input | ID_W (4) | Owning requestor id |
| req_bg_i | input | BG_W (2) | Bank group |
| req_bank_i | input | BANK_W (2) | Bank |
| req_row_i | input | ROW_W (14) | Row address |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| cmd_valid_o | output | 1 | Command is not NOP |
| cmd_o | output | 3 | Command code |
| cmd_id_o | output | ID_W (4) | Requestor id of the served request |
| cmd_bg_o | output | BG_W (2) | Bank group of the served request |
| cmd_bank_o | output | BANK_W (2) | Bank of the served request |
| cmd_row_o | output | ROW_W (14) | Row of the served request |
| cmd_wr_o | output | 1 | Direction of the served request |

## Verification
The hardest situation to reach is the refresh gate. The owner's slot opens, a request is waiting, and still no PRE may appear because a full rotation would overrun the refresh deadline. Reaching it needs requests queued for every owner across the whole refresh interval. A directed run therefore preloads alternating owners right after reset and counts the accesses that start before the first PREA. A second directed run fills the store past capacity and then pushes one more request in exactly the cycle of the first removal. This exercises the drop rule and the append-after-removal order together. A long random run compares every output cycle against a queue-based model.

// File: rtl/tdm_arb_pkg.sv
package tdm_arb_pkg;

    localparam int ID_W   = 4;
    localparam int BG_W   = 2;
    localparam int BANK_W = 2;
    localparam int ROW_W  = 14;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_PRE  = 3'd1,
        CMD_ACT  = 3'd2,
        CMD_RD   = 3'd3,
        CMD_WR   = 3'd4,
        CMD_PREA = 3'd5,
        CMD_REF  = 3'd6
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_REFR = 2'd2
    } arb_state_e;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [BG_W-1:0]   bg;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic              wr;
    } req_t;

    function automatic cmd_e column_cmd(input req_t r);
        return r.wr ? CMD_WR : CMD_RD;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int SN     = 2,
    parameter int SL     = 12,
    parameter int CYC_W  = 4,
    parameter int SLOT_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    output logic [CYC_W-1:0]  cyc_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SL - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_o  <= '0;
            slot_o <= '0;
        end else if (cyc_o == CYC_LAST) begin
            cyc_o  <= '0;
            slot_o <= (slot_o == SLOT_LAST) ? '0 : slot_o + 1'b1;
        end else begin
            cyc_o  <= cyc_o + 1'b1;
        end
    end

endmodule

// File: rtl/tdm_pend_store.sv
module tdm_pend_store
    import tdm_arb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push_i,
    input  req_t            push_req_i,
    input  logic [ID_W-1:0] sel_id_i,
    input  logic            pop_i,
    output logic            hit_o,
    output req_t            hit_req_o
);

    req_t             ent_q [DEPTH];
    req_t             ent_n [DEPTH];
    req_t             shifted [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_after;
    logic [IDX_W-1:0] hit_idx;
    logic             push_ok;

    // oldest matching entry: scan from the top so the lowest index wins
    always_comb begin
        hit_o   = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if ((CNT_W'(i) < cnt_q) && (ent_q[i].id == sel_id_i)) begin
                hit_o   = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
        hit_req_o = ent_q[hit_idx];
    end

    // removal closes the gap, then the arrival takes the first free place
    always_comb begin
        for (int i = 0; i < DEPTH - 1; i++) begin
            shifted[i] = (pop_i && (IDX_W'(i) >= hit_idx)) ? ent_q[i + 1] : ent_q[i];
        end
        shifted[DEPTH - 1] = pop_i ? '0 : ent_q[DEPTH - 1];

        cnt_after = cnt_q - CNT_W'(pop_i);
        push_ok   = push_i && (cnt_after != CNT_W'(DEPTH));
        for (int i = 0; i < DEPTH; i++) begin
            ent_n[i] = (push_ok && (CNT_W'(i) == cnt_after)) ? push_req_i : shifted[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            cnt_q <= cnt_after + CNT_W'(push_ok);
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
        end
    end

endmodule

// File: rtl/tdm_cmd_arbiter.sv
module tdm_cmd_arbiter
    import tdm_arb_pkg::*;
#(
    parameter int SN     = 2,
    parameter int SL     = 12,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 9,
    parameter int T_FAW  = 8,
    parameter int T_REFI = 80,
    parameter int T_RFC  = 10,
    parameter int QDEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid_i,
    input  logic [ID_W-1:0]   req_id_i,
    input  logic [BG_W-1:0]   req_bg_i,
    input  logic [BANK_W-1:0] req_bank_i,
    input  logic [ROW_W-1:0]  req_row_i,
    input  logic              req_wr_i,
    output logic              cmd_valid_o,
    output logic [2:0]        cmd_o,
    output logic [ID_W-1:0]   cmd_id_o,
    output logic [BG_W-1:0]   cmd_bg_o,
    output logic [BANK_W-1:0] cmd_bank_o,
    output logic [ROW_W-1:0]  cmd_row_o,
    output logic              cmd_wr_o
);

    localparam int PREA_DATE = T_REFI - T_RP;
    localparam int REF_AT    = T_RP - 1;
    localparam int REF_END   = REF_AT + T_RFC;
    localparam int PERIOD    = SN * SL;
    localparam int ACT_AT    = T_RP;
    localparam int CAS_AT    = T_RP + T_RCD;
    localparam int CYC_W     = $clog2(SL);
    localparam int SLOT_W    = $clog2(SN);
    localparam int REF_W     = $clog2(PREA_DATE + 1);

    // parameter sets that break the fixed offsets stop elaboration
    if (SL <= CAS_AT + 1) begin : g_bad_cas
        $error("slot too short for activate-to-column delay");
    end
    if (SL <= T_RC) begin : g_bad_rc
        $error("slot too short for row cycle time");
    end
    if (SL <= T_RP + T_RAS) begin : g_bad_ras
        $error("slot too short for row active time");
    end
    if (T_FAW >= 3 * SL) begin : g_bad_faw
        $error("four-activate window too long for slot");
    end
    if (T_RP < 2 || T_REFI <= T_RP || REF_END >= PREA_DATE) begin : g_bad_ref
        $error("refresh timing inconsistent");
    end
    if (SN < 2 || SN > (1 << ID_W)) begin : g_bad_sn
        $error("requestor count out of range");
    end

    logic [CYC_W-1:0]  cyc_w;
    logic [SLOT_W-1:0] slot_w;
    logic [REF_W-1:0]  refcnt_q, refcnt_n, ref_inc;
    arb_state_e        state_q, state_n;
    req_t              cur_q, cur_n, in_req, hit_req, out_n, out_q;
    cmd_e              cmd_n, cmd_q;
    logic              hit, pop, room;

    assign in_req = '{id: req_id_i, bg: req_bg_i, bank: req_bank_i,
                      row: req_row_i, wr: req_wr_i};

    tdm_slot_timer #(.SN(SN), .SL(SL), .CYC_W(CYC_W), .SLOT_W(SLOT_W)) timer_i (
        .clk    (clk),
        .rst    (rst),
        .cyc_o  (cyc_w),
        .slot_o (slot_w)
    );

    tdm_pend_store #(.DEPTH(QDEPTH)) store_i (
        .clk        (clk),
        .rst        (rst),
        .push_i     (req_valid_i),
        .push_req_i (in_req),
        .sel_id_i   (ID_W'(slot_w)),
        .pop_i      (pop),
        .hit_o      (hit),
        .hit_req_o  (hit_req)
    );

    assign room    = (int'(refcnt_q) + PERIOD) < PREA_DATE;
    assign ref_inc = (refcnt_q == REF_W'(PREA_DATE)) ? '0 : refcnt_q + 1'b1;

    always_comb begin
        state_n  = state_q;
        refcnt_n = ref_inc;
        cur_n    = cur_q;
        cmd_n    = CMD_NOP;
        out_n    = '0;
        pop      = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (room) begin
                    if (cyc_w == '0 && hit) begin
                        pop     = 1'b1;
                        cmd_n   = CMD_PRE;
                        out_n   = hit_req;
                        cur_n   = hit_req;
                        state_n = ST_BUSY;
                    end
                end else if (refcnt_q == REF_W'(PREA_DATE)) begin
                    cmd_n    = CMD_PREA;
                    refcnt_n = '0;
                    state_n  = ST_REFR;
                end
            end
            ST_BUSY: begin
                if (cyc_w == CYC_W'(ACT_AT)) begin
                    cmd_n = CMD_ACT;
                    out_n = cur_q;
                end else if (cyc_w == CYC_W'(CAS_AT)) begin
                    cmd_n = column_cmd(cur_q);
                    out_n = cur_q;
                end else if (cyc_w == CYC_W'(SL - 1)) begin
                    state_n = ST_IDLE;
                end else begin
                    out_n = cur_q;
                end
            end
            ST_REFR: begin
                if (refcnt_q == REF_W'(REF_AT)) begin
                    cmd_n = CMD_REF;
                end else if (refcnt_q == REF_W'(REF_END)) begin
                    state_n  = ST_IDLE;
                    refcnt_n = '0;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            refcnt_q <= '0;
            cur_q    <= '0;
            cmd_q    <= CMD_NOP;
            out_q    <= '0;
        end else begin
            state_q  <= state_n;
            refcnt_q <= refcnt_n;
            cur_q    <= cur_n;
            cmd_q    <= cmd_n;
            out_q    <= out_n;
        end
    end

    assign cmd_valid_o = (cmd_q != CMD_NOP);
    assign cmd_o       = cmd_q;
    assign cmd_id_o    = out_q.id;
    assign cmd_bg_o    = out_q.bg;
    assign cmd_bank_o  = out_q.bank;
    assign cmd_row_o   = out_q.row;
    assign cmd_wr_o    = out_q.wr;

endmodule

// File: rtl/tdm_cmd_arbiter_chk.sv
module tdm_cmd_arbiter_chk
    import tdm_arb_pkg::*;
#(
    parameter int SN     = 2,
    parameter int SL     = 12,
    parameter int T_RP   = 3,
    parameter int T_RCD  = 3,
    parameter int T_REFI = 80,
    parameter int CYC_W  = 4,
    parameter int SLOT_W = 1,
    parameter int REF_W  = 7
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        cmd,
    input logic [ID_W-1:0]   cmd_id,
    input logic [CYC_W-1:0]  cyc,
    input logic [SLOT_W-1:0] slot,
    input logic [REF_W-1:0]  refcnt
);

    localparam int PREA_DATE = T_REFI - T_RP;
    localparam int SAT       = 1 << 20;

    int since_pre, since_prea;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre  <= SAT;
            since_prea <= SAT;
        end else begin
            since_pre  <= (cmd == CMD_PRE)  ? 1 : ((since_pre  < SAT) ? since_pre  + 1 : SAT);
            since_prea <= (cmd == CMD_PREA) ? 1 : ((since_prea < SAT) ? since_prea + 1 : SAT);
        end
    end

    // R4
    act_after_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_ACT) |-> (since_pre == T_RP));

    // R4
    cas_after_pre_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RD || cmd == CMD_WR) |-> (since_pre == T_RP + T_RCD));

    // R7
    ref_after_prea_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF) |-> (since_prea == T_RP));

    // R2
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc != '0) |-> $stable(slot));

    // R2
    cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cyc) < SL);

    // R3
    pre_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> (cmd_id == ID_W'(slot)));

    // R5
    pre_room_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE) |-> (int'(refcnt) + SN * SL <= PREA_DATE));

    // R6
    ref_bound_chk: assert property (@(posedge clk) disable iff (rst)
        int'(refcnt) <= PREA_DATE);

endmodule

bind tdm_cmd_arbiter tdm_cmd_arbiter_chk #(
    .SN(SN), .SL(SL), .T_RP(T_RP), .T_RCD(T_RCD), .T_REFI(T_REFI),
    .CYC_W(CYC_W), .SLOT_W(SLOT_W), .REF_W(REF_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .cmd    (cmd_o),
    .cmd_id (cmd_id_o),
    .cyc    (cyc_w),
    .slot   (slot_w),
    .refcnt (refcnt_q)
);

// File: tb/tdm_cmd_arbiter_tb_top.sv
`timescale 1ns/1ps
module tdm_cmd_arbiter_tb_top;
    import tdm_arb_pkg::*;

    localparam int SN     = 2;
    localparam int SL     = 12;
    localparam int T_RP   = 3;
    localparam int T_RCD  = 3;
    localparam int T_REFI = 80;
    localparam int T_RFC  = 10;
    localparam int QDEPTH = 8;
    localparam int PREA   = T_REFI - T_RP;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst = 1'b1;
    logic              req_valid_i = 1'b0;
    logic [ID_W-1:0]   req_id_i = '0;
    logic [BG_W-1:0]   req_bg_i = '0;
    logic [BANK_W-1:0] req_bank_i = '0;
    logic [ROW_W-1:0]  req_row_i = '0;
    logic              req_wr_i = 1'b0;
    logic              cmd_valid_o;
    logic [2:0]        cmd_o;
    logic [ID_W-1:0]   cmd_id_o;
    logic [BG_W-1:0]   cmd_bg_o;
    logic [BANK_W-1:0] cmd_bank_o;
    logic [ROW_W-1:0]  cmd_row_o;
    logic              cmd_wr_o;

    tdm_cmd_arbiter #(.SN(SN), .SL(SL), .T_RP(T_RP), .T_RCD(T_RCD),
                      .T_REFI(T_REFI), .T_RFC(T_RFC), .QDEPTH(QDEPTH)) dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_id_i(req_id_i),
        .req_bg_i(req_bg_i), .req_bank_i(req_bank_i), .req_row_i(req_row_i),
        .req_wr_i(req_wr_i), .cmd_valid_o(cmd_valid_o), .cmd_o(cmd_o),
        .cmd_id_o(cmd_id_o), .cmd_bg_o(cmd_bg_o), .cmd_bank_o(cmd_bank_o),
        .cmd_row_o(cmd_row_o), .cmd_wr_o(cmd_wr_o)
    );

    int    n_chk = 0, n_err = 0, tick_no = 0;
    bit    armed = 0, done = 0;
    int    e_code;
    req_t  e_req;
    string e_tag = "R1";
    int    obs_code, obs_valid, obs_row;

    // behavioural model state
    int   m_st, m_cyc, m_slot, m_ref;
    req_t m_cur;
    req_t m_q[$];

    task automatic check(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic req_t mk(int id, int row, bit wr);
        req_t r;
        r.id   = ID_W'(id);
        r.bg   = BG_W'(row);
        r.bank = BANK_W'(row >> 2);
        r.row  = ROW_W'(row);
        r.wr   = wr;
        return r;
    endfunction

    function automatic void model_step(bit r, bit v, req_t rq);
        int  idx;
        bit  pend;
        e_code = 0;
        e_req  = '0;
        e_tag  = "R9";
        if (r) begin
            m_st = 0; m_cyc = 0; m_slot = 0; m_ref = 0; m_cur = '0;
            m_q.delete();
            e_tag = "R1";
            return;
        end
        pend = 0;
        foreach (m_q[i]) if (m_q[i].id == ID_W'(m_slot)) pend = 1;
        case (m_st)
            0: begin
                if (m_ref + SN * SL < PREA) begin
                    if (m_cyc == 0) begin
                        idx = -1;
                        foreach (m_q[i]) if (idx < 0 && m_q[i].id == ID_W'(m_slot)) idx = i;
                        if (idx >= 0) begin
                            e_code = 1; e_req = m_q[idx]; m_cur = m_q[idx];
                            m_q.delete(idx); m_st = 1; e_tag = "R3";
                        end
                    end
                    m_ref++;
                end else if (m_ref == PREA) begin
                    e_code = 5; m_ref = 0; m_st = 2; e_tag = "R6";
                end else begin
                    m_ref++;
                    if (m_cyc == 0 && pend) e_tag = "R5";
                end
            end
            1: begin
                m_ref++;
                e_tag = "R4";
                if (m_cyc == T_RP) begin
                    e_code = 2; e_req = m_cur;
                end else if (m_cyc == T_RP + T_RCD) begin
                    e_code = m_cur.wr ? 4 : 3; e_req = m_cur;
                end else if (m_cyc == SL - 1) begin
                    m_st = 0;
                end else begin
                    e_req = m_cur;
                end
            end
            default: begin
                e_tag = "R7";
                if (m_ref == T_RP - 1) begin
                    e_code = 6; m_ref++;
                end else if (m_ref == T_RP - 1 + T_RFC) begin
                    m_st = 0; m_ref = 0;
                end else begin
                    m_ref++;
                end
            end
        endcase
        if (v) begin
            if (m_q.size() < QDEPTH) m_q.push_back(rq);
            else e_tag = "R8";
        end
        if (m_cyc == SL - 1) begin
            m_cyc = 0;
            m_slot = (m_slot + 1) % SN;
        end else begin
            m_cyc++;
        end
    endfunction

    task automatic tick(bit r, bit v, req_t rq);
        logic [26:0] act, exp;
        @(negedge clk);
        act = {cmd_valid_o, cmd_o, cmd_id_o, cmd_bg_o, cmd_bank_o, cmd_row_o, cmd_wr_o};
        exp = {(e_code != 0), 3'(e_code), e_req};
        if (armed) begin
            n_chk++;
            if (act !== exp) begin
                n_err++;
                $display("FAIL %s tick %0d: actual=%h expected=%h", e_tag, tick_no, act, exp);
            end
        end
        obs_code  = int'(cmd_o);
        obs_valid = int'(cmd_valid_o);
        obs_row   = int'(cmd_row_o);
        rst         = r;
        req_valid_i = v;
        req_id_i    = rq.id;
        req_bg_i    = rq.bg;
        req_bank_i  = rq.bank;
        req_row_i   = rq.row;
        req_wr_i    = rq.wr;
        model_step(r, v, rq);
        armed = 1;
        tick_no++;
    endtask

    initial begin : watchdog
        #(4 * 100000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : stim
        int first_pre, first_prea, first_ref, npre, exp_pre;
        int rows[$];

        // scenario 1: reset, alternating owners, first refresh
        repeat (3) tick(1, 0, '0);
        tick_no = 0;
        first_pre = -1; first_prea = -1; first_ref = -1; npre = 0;
        for (int k = 1; k <= 6; k++) begin
            tick(0, 1, mk(k % SN, k, k[1]));
            if (k == 1) begin
                check("R1", obs_code, 0, "code after reset");
                check("R1", obs_valid, 0, "valid after reset");
            end
            if (obs_code == 1 && first_pre < 0) first_pre = tick_no;
            if (obs_code == 1) npre++;
        end
        while (tick_no < 200) begin
            tick(0, 0, '0);
            if (obs_code == 1 && first_pre < 0) first_pre = tick_no;
            if (obs_code == 1 && first_prea < 0) npre++;
            if (obs_code == 5 && first_prea < 0) first_prea = tick_no;
            if (obs_code == 6 && first_ref < 0) first_ref = tick_no;
        end
        exp_pre = 0;
        for (int m = SL; m + SN * SL < PREA; m += SL) exp_pre++;
        if (exp_pre > 6) exp_pre = 6;
        check("R2", first_pre, SL + 2, "tick of first PRE (owner 1)");
        check("R5", npre, exp_pre, "accesses before first refresh");
        check("R6", first_prea, PREA + 2, "tick of first PREA");
        check("R7", first_ref, PREA + T_RP + 2, "tick of first REF");

        // scenario 2: overfill owner 0, push during the first removal
        repeat (2) tick(1, 0, '0);
        tick_no = 0;
        for (int k = 0; k <= QDEPTH; k++) tick(0, 1, mk(0, 100 + k, 1'b0));
        while (tick_no < SN * SL) tick(0, 0, '0);
        tick(0, 1, mk(0, 200, 1'b1));
        while (tick_no < 900) begin
            tick(0, 0, '0);
            if (obs_code == 1) rows.push_back(obs_row);
        end
        check("R8", rows.size(), QDEPTH + 1, "served count");
        for (int i = 0; i < rows.size() && i <= QDEPTH; i++)
            check("R8", rows[i], (i < QDEPTH) ? 100 + i : 200, "served row order");

        // scenario 3: random traffic against the model
        repeat (2) tick(1, 0, '0);
        for (int k = 0; k < 5000; k++) begin
            bit v;
            v = ($urandom % 100) < 35;
            tick(0, v, mk(int'($urandom % SN), int'($urandom % 4096), 1'($urandom)));
        end
        tick(0, 0, '0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule